// File: doc/BRIEF.md
# Mouse Stream-Enable Controller

This block wakes a pointing device on a two-wire serial port, where the clock and data lines are open-collector and idle high. After reset it holds the clock line low long enough to silence the device. While the clock is still held it pulls the data line low to request a transfer, drives the clock high for a few cycles, and then lets go of it. The device then clocks in a one-byte command, which by default turns on streaming mode. The block presents each command bit after a falling edge of the device's clock, followed by an odd parity bit and a released stop level.

After the command the block releases both lines and reads back the device's eleven-bit reply. It raises a sticky done flag when the reply byte is the expected acknowledge. It raises a sticky error flag on a framing fault, a parity fault, a wrong byte, or a device that stops clocking. In both cases it never drives either line again. The two line inputs pass through two-flop synchronizers, and a registered copy of the synchronized clock produces a falling-edge strobe.

Top module: `mouse_wake_ctrl`

## Requirements
- R1: From reset the block drives the clock line low (`mclk_oe`=1, `mclk_out`=0) with data released (`mdat_oe`=0), for exactly INHIBIT_CYC cycles after reset is released. The default of 1440 is 60 µs at 24 MHz.
- R2: After the hold time the block pulls data low (`mdat_oe`=1, `mdat_out`=0) while the clock stays driven low, for RTS_CYC cycles.
- R3: The block then drives the clock high (`mclk_out`=1) for RELEASE_CYC cycles with data still low, and then tri-states the clock. It never drives the clock again until the next reset.
- R4: Each falling edge of the device clock moves the data output to the next bit: the eight bits of CMD_BYTE least significant first, then the odd parity bit (0 for 0xF4). A change appears at the third rising system-clock edge after the low level is first sampled.
- R5: On the tenth falling edge the block releases data, which gives a high stop bit, and starts receiving.
- R6: The reply is read on eleven falling edges: start bit 0, eight data bits least significant first, a parity bit that makes the nine bits odd, and stop bit 1. If the reply is valid and the byte is ACK_BYTE (0xFA), `init_done` rises one cycle after the eleventh edge is detected.
- R7: A reply with a wrong byte, wrong parity, a start bit of 1 or a stop bit of 0 raises `init_err` instead of `init_done`.
- R8: While sending or receiving, if TIMEOUT_CYC cycles pass with no falling edge, `init_err` rises. The count restarts at each edge and at entry to the send phase.
- R9: `init_done` and `init_err` are sticky and never high together. While either is high, both lines are released and further device clocking has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_in | input | 1 | Level seen on the shared clock line |
| mdat_in | input | 1 | Level seen on the shared data line |
| mclk_oe | output | 1 | Clock line driver enable |
| mclk_out | output | 1 | Value driven on the clock line when enabled |
| mdat_oe | output | 1 | Data line driver enable |
| mdat_out | output | 1 | Value driven on the data line when enabled |
| init_done | output | 1 | Valid acknowledge received (sticky) |
| init_err | output | 1 | Reply fault or timeout (sticky) |

## Verification
An error in the phase sequence shows at the driver enables at once. A phase that ends one cycle early or late changes the cycle in which `mdat_oe` rises or `mclk_oe` falls, and the per-cycle reference comparison catches that on the same clock. An error in the send shifter shows at the data output within three cycles of the falling edge that should have moved it. The emulated device also decodes the bits it samples on its rising edges, so a wrong bit order or parity shows as a wrong byte. Errors in the receive check or the timeout count show only in the flags. Each reply fault and each stall is therefore placed so that the flag must change in one exact cycle, and the cycle before it is checked too.

// File: rtl/ps2i_pkg.sv
package ps2i_pkg;

  typedef enum logic [2:0] {
    ST_HOLD    = 3'd0,
    ST_REQ     = 3'd1,
    ST_LIFT    = 3'd2,
    ST_SEND    = 3'd3,
    ST_RECV    = 3'd4,
    ST_READY   = 3'd5,
    ST_FAULT   = 3'd6
  } wake_st_e;

  localparam int TX_BITS = 9;   // data plus parity
  localparam int RX_BITS = 11;  // start, data, parity, stop

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/ps2i_sync.sv
module ps2i_sync #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end

endmodule

// File: rtl/ps2i_fall_det.sv
module ps2i_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl;
  end

  assign fall = prev_q & ~lvl;

endmodule

// File: rtl/ps2i_cnt.sv
module ps2i_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/mouse_wake_ctrl.sv
module mouse_wake_ctrl
  import ps2i_pkg::*;
#(
  parameter int         INHIBIT_CYC = 1440,
  parameter int         RTS_CYC     = 24,
  parameter int         RELEASE_CYC = 4,
  parameter int         TIMEOUT_CYC = 480000,
  parameter logic [7:0] CMD_BYTE    = 8'hF4,
  parameter logic [7:0] ACK_BYTE    = 8'hFA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_in,
  input  logic mdat_in,
  output logic mclk_oe,
  output logic mclk_out,
  output logic mdat_oe,
  output logic mdat_out,
  output logic init_done,
  output logic init_err
);

  localparam int MAX_A = (INHIBIT_CYC > TIMEOUT_CYC) ? INHIBIT_CYC : TIMEOUT_CYC;
  localparam int MAX_B = (RTS_CYC > RELEASE_CYC) ? RTS_CYC : RELEASE_CYC;
  localparam int MAXL  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXL + 1);
  localparam int NBW   = $clog2(RX_BITS + 1);

  logic          clk_s, dat_s, fall;
  logic [CW-1:0] cnt, lim;
  logic          hit, cnt_en, cnt_clr, xfer;

  wake_st_e            state_q, state_d;
  logic [TX_BITS-1:0]  tx_q, tx_d;
  logic [RX_BITS-1:0]  rx_q, rx_d, frame;
  logic [NBW-1:0]      nb_q, nb_d;
  logic                dat_q, dat_d, doe_q, doe_d, reply_ok;

  ps2i_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mclk_in, mdat_in}), .q({clk_s, dat_s})
  );

  ps2i_fall_det u_fall (.clk(clk), .rst_n(rst_n), .lvl(clk_s), .fall(fall));

  ps2i_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(cnt_clr), .cnt(cnt)
  );

  // phase length / stall limit for the shared counter
  always_comb begin
    unique case (state_q)
      ST_HOLD: lim = CW'(INHIBIT_CYC - 1);
      ST_REQ:  lim = CW'(RTS_CYC - 1);
      ST_LIFT: lim = CW'(RELEASE_CYC - 1);
      default: lim = CW'(TIMEOUT_CYC - 1);
    endcase
  end

  assign hit     = (cnt == lim);
  assign xfer    = (state_q == ST_SEND) || (state_q == ST_RECV);
  assign cnt_en  = (state_q != ST_READY) && (state_q != ST_FAULT);
  assign cnt_clr = (state_d != state_q) || (xfer && fall);

  assign frame    = {dat_s, rx_q[RX_BITS-1:1]};
  assign reply_ok = !frame[0] && frame[RX_BITS-1] && (frame[8:1] == ACK_BYTE)
                    && (^frame[9:1]);

  always_comb begin
    state_d = state_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    nb_d    = nb_q;
    dat_d   = dat_q;
    doe_d   = doe_q;
    unique case (state_q)
      ST_HOLD: if (hit) begin
        state_d = ST_REQ;
        doe_d   = 1'b1;
        dat_d   = 1'b0;
      end
      ST_REQ: if (hit) state_d = ST_LIFT;
      ST_LIFT: if (hit) begin
        state_d = ST_SEND;
        tx_d    = {odd_par(CMD_BYTE), CMD_BYTE};
        nb_d    = '0;
      end
      ST_SEND: begin
        if (fall) begin
          if (nb_q == NBW'(TX_BITS)) begin
            doe_d   = 1'b0;
            state_d = ST_RECV;
            nb_d    = '0;
          end else begin
            dat_d = tx_q[0];
            tx_d  = tx_q >> 1;
            nb_d  = nb_q + 1'b1;
          end
        end else if (hit) begin
          state_d = ST_FAULT;
          doe_d   = 1'b0;
        end
      end
      ST_RECV: begin
        if (fall) begin
          rx_d = frame;
          if (nb_q == NBW'(RX_BITS - 1)) state_d = reply_ok ? ST_READY : ST_FAULT;
          else                            nb_d    = nb_q + 1'b1;
        end else if (hit) begin
          state_d = ST_FAULT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      tx_q    <= '0;
      rx_q    <= '0;
      nb_q    <= '0;
      dat_q   <= 1'b0;
      doe_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      nb_q    <= nb_d;
      dat_q   <= dat_d;
      doe_q   <= doe_d;
    end
  end

  assign mclk_oe   = (state_q == ST_HOLD) || (state_q == ST_REQ) || (state_q == ST_LIFT);
  assign mclk_out  = (state_q == ST_LIFT);
  assign mdat_oe   = doe_q;
  assign mdat_out  = dat_q;
  assign init_done = (state_q == ST_READY);
  assign init_err  = (state_q == ST_FAULT);

endmodule

// File: rtl/mouse_wake_ctrl_chk.sv
module mouse_wake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic mclk_in,
  input logic mclk_oe,
  input logic mclk_out,
  input logic mdat_oe,
  input logic mdat_out,
  input logic init_done,
  input logic init_err
);

  logic clk_let_go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_let_go_q <= 1'b0;
    else        clk_let_go_q <= clk_let_go_q | !mclk_oe;
  end

  assert_clk_never_again_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_let_go_q |-> !mclk_oe);

  assert_high_drive_with_low_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mclk_oe && mclk_out) |-> (mdat_oe && !mdat_out));

  assert_request_under_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdat_oe) |-> (mclk_oe && !mclk_out));

  assert_shift_while_clk_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_oe && mdat_oe && !$stable(mdat_out)) |-> !$past(mclk_in, 2));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_err |=> init_err);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_done && init_err));

  assert_quiet_after_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || init_err) |-> (!mclk_oe && !mdat_oe));

endmodule

bind mouse_wake_ctrl mouse_wake_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .mclk_oe(mclk_oe),
  .mclk_out(mclk_out), .mdat_oe(mdat_oe), .mdat_out(mdat_out),
  .init_done(init_done), .init_err(init_err)
);

// File: tb/mouse_wake_ctrl_tb_top.sv
module mouse_wake_ctrl_tb_top;

  localparam int         P_INH  = 100;
  localparam int         P_RTS  = 8;
  localparam int         P_REL  = 4;
  localparam int         P_TO   = 400;
  localparam logic [7:0] P_CMD  = 8'hF4;
  localparam logic [7:0] P_ACK  = 8'hFA;
  localparam int         HALF   = 10;

  logic clk, rst_n;
  logic m_clk_drv, m_dat_drv;
  logic mclk_oe, mclk_out, mdat_oe, mdat_out, init_done, init_err;
  wire  clk_line = m_clk_drv & (mclk_oe ? mclk_out : 1'b1);
  wire  dat_line = m_dat_drv & (mdat_oe ? mdat_out : 1'b1);

  int checks, failures;

  mouse_wake_ctrl #(
    .INHIBIT_CYC(P_INH), .RTS_CYC(P_RTS), .RELEASE_CYC(P_REL),
    .TIMEOUT_CYC(P_TO), .CMD_BYTE(P_CMD), .ACK_BYTE(P_ACK)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mclk_in(clk_line), .mdat_in(dat_line),
    .mclk_oe(mclk_oe), .mclk_out(mclk_out), .mdat_oe(mdat_oe),
    .mdat_out(mdat_out), .init_done(init_done), .init_err(init_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // phases: 0 hold, 1 request, 2 lift, 3 send, 4 receive, 5 done, 6 error
  int         m_ph, m_cnt, m_nb;
  logic       m_doe, m_dv;
  logic [10:0] m_rx;
  bit         cq[$], dq[$];

  always @(posedge clk or negedge rst_n) begin
    bit f, db;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_nb = 0; m_doe = 0; m_dv = 0; m_rx = '0;
      cq = '{1, 1, 1}; dq = '{1, 1, 1};
    end else begin
      f  = cq[0] && !cq[1];
      db = dq[1];
      cq.push_back(clk_line); void'(cq.pop_front());
      dq.push_back(dat_line); void'(dq.pop_front());
      case (m_ph)
        0: if (m_cnt == P_INH - 1) begin m_ph = 1; m_cnt = 0; m_doe = 1; m_dv = 0; end
           else m_cnt++;
        1: if (m_cnt == P_RTS - 1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
        2: if (m_cnt == P_REL - 1) begin m_ph = 3; m_cnt = 0; m_nb = 0; end else m_cnt++;
        3: if (f) begin
             m_cnt = 0;
             if (m_nb == 9) begin m_doe = 0; m_ph = 4; m_nb = 0; end
             else begin
               m_dv = (m_nb == 8) ? ~^P_CMD : P_CMD[m_nb];
               m_nb++;
             end
           end else if (m_cnt == P_TO - 1) begin m_ph = 6; m_doe = 0; end
           else m_cnt++;
        4: if (f) begin
             m_cnt = 0;
             m_rx[m_nb] = db;
             if (m_nb == 10)
               m_ph = (!m_rx[0] && m_rx[10] && m_rx[8:1] == P_ACK && (^m_rx[9:1])) ? 5 : 6;
             else m_nb++;
           end else if (m_cnt == P_TO - 1) m_ph = 6;
           else m_cnt++;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(mclk_oe == (m_ph <= 2), "R1/R3", "model clk_oe", mclk_oe, m_ph <= 2);
      chk(mclk_out == (m_ph == 2), "R3", "model clk_out", mclk_out, m_ph == 2);
      chk(mdat_oe == m_doe, "R2/R5", "model dat_oe", mdat_oe, m_doe);
      if (m_doe) chk(mdat_out == m_dv, "R4", "model dat_out", mdat_out, m_dv);
      chk(init_done == (m_ph == 5), "R6", "model done", init_done, m_ph == 5);
      chk(init_err == (m_ph == 6), "R7/R8", "model err", init_err, m_ph == 6);
    end
  end

  // ---------------- device emulation ----------------
  task automatic pulse(output bit smp);
    repeat (HALF) @(negedge clk);
    m_clk_drv = 1'b0;
    repeat (HALF) @(negedge clk);
    m_clk_drv = 1'b1;
    smp = dat_line;
  endtask

  task automatic start_up();
    int n;
    rst_n = 1'b0; m_clk_drv = 1'b1; m_dat_drv = 1'b1;
    repeat (3) @(negedge clk);
    chk(mclk_oe && !mclk_out && !mdat_oe && !init_done && !init_err, "R1",
        "reset outputs", {mclk_oe, mclk_out, mdat_oe, init_done, init_err}, 5'b10000);
    rst_n = 1'b1;
    n = 0;
    while (!mdat_oe && n < 1000) begin n++; @(negedge clk); end
    chk(n == P_INH, "R1", "hold cycles", n, P_INH);
    n = 0;
    while (mclk_oe && !mclk_out && mdat_oe && !mdat_out && n < 1000) begin n++; @(negedge clk); end
    chk(n == P_RTS, "R2", "request cycles", n, P_RTS);
    n = 0;
    while (mclk_oe && mclk_out && mdat_oe && !mdat_out && n < 1000) begin n++; @(negedge clk); end
    chk(n == P_REL, "R3", "lift cycles", n, P_REL);
    chk(!mclk_oe, "R3", "clock released", mclk_oe, 0);
  endtask

  task automatic take_command();
    bit b;
    logic [9:0] got;
    for (int i = 0; i < 10; i++) begin pulse(b); got[i] = b; end
    chk(got[7:0] == P_CMD, "R4", "command byte", got[7:0], P_CMD);
    chk(got[8] == 1'b0, "R4", "parity bit", got[8], 0);
    chk(got[9] == 1'b1, "R5", "stop level", got[9], 1);
    chk(!mdat_oe, "R5", "data released", mdat_oe, 0);
  endtask

  task automatic send_reply(input logic [10:0] fr, input int nbits);
    repeat (40) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      m_dat_drv = fr[i];
      repeat (HALF) @(negedge clk);
      m_clk_drv = 1'b0;
      repeat (HALF) @(negedge clk);
      m_clk_drv = 1'b1;
    end
    m_dat_drv = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [10:0] mk_frame(input logic [7:0] b, input bit bad_par,
                                           input bit bad_start, input bit bad_stop);
    return {~bad_stop, (~^b) ^ bad_par, b, bad_start};
  endfunction

  initial begin
    bit b;
    checks = 0; failures = 0;

    // good acknowledge
    start_up();
    take_command();
    send_reply(mk_frame(P_ACK, 0, 0, 0), 11);
    chk(init_done && !init_err, "R6", "done after ack", {init_done, init_err}, 2'b10);
    for (int i = 0; i < 11; i++) begin m_dat_drv = i[0]; pulse(b); end
    m_dat_drv = 1'b1;
    repeat (5) @(negedge clk);
    chk(init_done && !init_err && !mclk_oe && !mdat_oe, "R9", "ignored after done",
        {init_done, init_err, mclk_oe, mdat_oe}, 4'b1000);

    // wrong acknowledge byte
    start_up(); take_command();
    send_reply(mk_frame(8'hFE, 0, 0, 0), 11);
    chk(init_err && !init_done, "R7", "wrong byte", {init_done, init_err}, 2'b01);

    // parity fault
    start_up(); take_command();
    send_reply(mk_frame(P_ACK, 1, 0, 0), 11);
    chk(init_err && !init_done, "R7", "bad parity", {init_done, init_err}, 2'b01);

    // stop bit low
    start_up(); take_command();
    send_reply(mk_frame(P_ACK, 0, 0, 1), 11);
    chk(init_err && !init_done, "R7", "bad stop", {init_done, init_err}, 2'b01);

    // start bit high
    start_up(); take_command();
    send_reply(mk_frame(P_ACK, 0, 1, 0), 11);
    chk(init_err && !init_done, "R7", "bad start", {init_done, init_err}, 2'b01);

    // device never clocks: exact stall window
    start_up();
    repeat (P_TO - 2) @(negedge clk);
    chk(!init_err, "R8", "no error before window", init_err, 0);
    repeat (2) @(negedge clk);
    chk(init_err && !mdat_oe, "R8", "send stall error", {init_err, mdat_oe}, 2'b10);

    // device stops mid reply
    start_up(); take_command();
    send_reply(mk_frame(P_ACK, 0, 0, 0), 4);
    repeat (P_TO + 20) @(negedge clk);
    chk(init_err && !init_done, "R8", "receive stall error", {init_done, init_err}, 2'b01);
    for (int i = 0; i < 11; i++) pulse(b);
    repeat (5) @(negedge clk);
    chk(init_err && !init_done && !mdat_oe && !mclk_oe, "R9", "ignored after error",
        {init_done, init_err, mclk_oe, mdat_oe}, 4'b0100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule